// File: doc/BRIEF.md
# Dual-Select AHB Slave for Shared SRAM and Function Registers

This block is an AHB-Lite slave that overlays two targets on one offset space: a local word-organised SRAM and a 256-byte function-register field. The interconnect picks the target with a separate select line per region, so an offset such as 0x80 means an SRAM word under the memory select and a control register under the register select. A third select opens a read-only DMA view of the same SRAM, which uses the normal SRAM read path.

Every SRAM access (bus or DMA) must win an external arbiter first. The slave raises a request during the data phase and stalls the bus with HREADYOUT low until the grant comes back, then completes. Register accesses never wait. The register field holds three groups. The configuration group holds constants. The PCI-side group mirrors an input vector supplied from outside. The AHB-side group is the only part this port can change.

Top module: `ahbs_dual_region_slave`

## Requirements
- R1: During and directly after reset, HREADYOUT is 1, HRESP is 0 (OKAY), the arbiter request is 0 and every AHB-side register reads 0.
- R2: The memory select (sel_mem) and the register select (sel_reg) address disjoint storage at the same offset: a write through one is not seen through the other.
- R3: Register-field word offsets 0x80, 0x84 … 0xB0 (13 words) are writable and read back what was written.
- R4: Writes to any other register-field offset (configuration group, PCI-side group, unmapped, or any offset with HADDR above 0xFF) change nothing and complete with zero wait states and an OKAY response.
- R5: Register reads return the full 32-bit word: offset 0x00 gives the CFG_ID parameter, 0x04 gives the SRAM size in words, 0x08 and 0x0C give 0; offsets 0x40 + 4·i give bits [32i+31:32i] of pci_regs (i = 0..3); other unmapped offsets give 0.
- R6: In a data phase to the SRAM (bus read or write, or DMA read) arb_req is high and HREADYOUT stays low until arb_gnt is seen high. The transfer completes in the first cycle where the grant is high, and an SRAM write takes effect only at that edge.
- R7: Write byte lanes follow HSIZE and HADDR[1:0], little-endian: HSIZE 0 writes byte lane HADDR[1:0], HSIZE 1 writes lanes {HADDR[1],0} and {HADDR[1],1}, HSIZE 2 writes all four lanes. This holds for the SRAM and the AHB-side registers alike.
- R8: A read under the DMA select (sel_dma) returns the same SRAM word as a memory-select read of the same offset, with the same grant handshake.
- R9: A write under the DMA select leaves the SRAM unchanged, raises no request and ends with a two-cycle ERROR response: first HRESP=1 with HREADYOUT=0, then HRESP=1 with HREADYOUT=1.
- R10: The address, size, direction and select are captured in the address phase and applied in the following data phase, so that back-to-back pipelined transfers complete one per cycle when no wait is needed.
- R11: At most one of the three select lines may be high in an address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_mem | input | 1 | Select for the SRAM window |
| sel_reg | input | 1 | Select for the register field |
| sel_dma | input | 1 | Select for the read-only DMA view of the SRAM |
| haddr | input | AW | Transfer offset |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size (byte, halfword, word) |
| hwdata | input | 32 | Write data, data phase |
| hready_in | input | 1 | Bus-level ready; an address phase is taken when high |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| arb_req | output | 1 | SRAM access request to the arbiter |
| arb_gnt | input | 1 | SRAM access grant from the arbiter |
| pci_regs | input | 32·PCI_WORDS | PCI-side register values, word i at bits [32i+31:32i] |

## Verification
The bench mixes a fixed-seed random stream with directed cases. The random stream picks the region, offset, size, direction and arbiter grant delay (0 to 3 cycles) for each transfer and compares against bench models of the SRAM and the AHB-side group. It separates lane-masking errors from address-decode errors, and it shows whether the wait count follows the grant delay. Directed cases write the same offset through both selects to expose aliasing faults. They write protected and unmapped offsets to show that write protection holds group by group, and they issue a DMA write to check the exact two-cycle error shape and that the SRAM is left alone. A pipelined register burst shows that the address-phase capture is kept apart from the data-phase write data.

// File: rtl/ahbs_pkg.sv
package ahbs_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_MEM  = 2'd1,
    RG_REG  = 2'd2,
    RG_DMA  = 2'd3
  } region_e;

  // Little-endian byte lanes touched by a transfer of the given size
  function automatic logic [3:0] lane_mask(input logic [2:0] size, input logic [1:0] lo);
    case (size)
      3'd0:    lane_mask = 4'b0001 << lo;
      3'd1:    lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    for (int b = 0; b < 4; b++)
      lane_merge[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
  endfunction

endpackage

// File: rtl/ahbs_addr_phase.sv
module ahbs_addr_phase
  import ahbs_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready_in,
  input  logic [1:0]    htrans,
  input  logic          sel_mem,
  input  logic          sel_reg,
  input  logic          sel_dma,
  input  logic [AW-1:0] haddr,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  output logic          dp_valid,
  output region_e       dp_region,
  output logic          dp_write,
  output logic [3:0]    dp_be,
  output logic [AW-1:0] dp_addr
);

  logic          valid_d;
  region_e       region_d;
  logic          write_d;
  logic [3:0]    be_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    region_d = RG_NONE;
    if (sel_mem)      region_d = RG_MEM;
    else if (sel_reg) region_d = RG_REG;
    else if (sel_dma) region_d = RG_DMA;
    valid_d  = htrans[1] && (region_d != RG_NONE);
    write_d  = hwrite;
    be_d     = lane_mask(hsize, haddr[1:0]);
    addr_d   = haddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid  <= 1'b0;
      dp_region <= RG_NONE;
      dp_write  <= 1'b0;
      dp_be     <= 4'b0000;
      dp_addr   <= '0;
    end else if (hready_in) begin
      dp_valid  <= valid_d;
      dp_region <= region_d;
      dp_write  <= write_d;
      dp_be     <= be_d;
      dp_addr   <= addr_d;
    end
  end

endmodule

// File: rtl/ahbs_sram.sv
module ahbs_sram
  import ahbs_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (idx == IW'(w));
    always_ff @(posedge clk) begin
      if (hit) mem_q[w] <= lane_merge(mem_q[w], wdata, be);
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/ahbs_reg_field.sv
module ahbs_reg_field
  import ahbs_pkg::*;
#(
  parameter int          AW        = 12,
  parameter logic [31:0] CFG_ID    = 32'hB51D_0001,
  parameter int          MEM_WORDS = 64,
  parameter int          PCI_WORDS = 4,
  parameter int          AHB_WORDS = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic [32*PCI_WORDS-1:0] pci_regs,
  output logic [31:0]            rdata
);

  localparam int CFG_BASE = 0;   // word index of offset 0x00
  localparam int PCI_BASE = 16;  // word index of offset 0x40
  localparam int AHB_BASE = 32;  // word index of offset 0x80

  logic [5:0]  widx;
  logic        in_field;
  logic [31:0] ahb_q [AHB_WORDS];

  assign widx     = addr[7:2];
  assign in_field = (addr[AW-1:8] == '0);

  for (genvar r = 0; r < AHB_WORDS; r++) begin : g_ahb
    logic        hit;
    logic [31:0] nxt;
    assign hit = wr_en && in_field && (widx == 6'(AHB_BASE + r));
    assign nxt = hit ? lane_merge(ahb_q[r], wdata, be) : ahb_q[r];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ahb_q[r] <= '0;
      else        ahb_q[r] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_field) begin
      if (widx == 6'(CFG_BASE))          rdata = CFG_ID;
      else if (widx == 6'(CFG_BASE + 1)) rdata = 32'(MEM_WORDS);
      for (int p = 0; p < PCI_WORDS; p++)
        if (widx == 6'(PCI_BASE + p)) rdata = pci_regs[32*p +: 32];
      for (int r = 0; r < AHB_WORDS; r++)
        if (widx == 6'(AHB_BASE + r)) rdata = ahb_q[r];
    end
  end

endmodule

// File: rtl/ahbs_dual_region_slave.sv
module ahbs_dual_region_slave
  import ahbs_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          MEM_WORDS = 64,
  parameter int          PCI_WORDS = 4,
  parameter int          AHB_WORDS = 13,
  parameter logic [31:0] CFG_ID    = 32'hB51D_0001
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_mem,
  input  logic                    sel_reg,
  input  logic                    sel_dma,
  input  logic [AW-1:0]           haddr,
  input  logic [1:0]              htrans,
  input  logic                    hwrite,
  input  logic [2:0]              hsize,
  input  logic [31:0]             hwdata,
  input  logic                    hready_in,
  output logic [31:0]             hrdata,
  output logic                    hreadyout,
  output logic                    hresp,
  output logic                    arb_req,
  input  logic                    arb_gnt,
  input  logic [32*PCI_WORDS-1:0] pci_regs
);

  localparam int MIW = $clog2(MEM_WORDS);

  logic          dp_valid;
  region_e       dp_region;
  logic          dp_write;
  logic [3:0]    dp_be;
  logic [AW-1:0] dp_addr;
  logic          mem_phase, err_phase, mem_we, reg_we;
  logic          err_q, err_d;
  logic [31:0]   mem_rdata, reg_rdata;

  ahbs_addr_phase #(.AW(AW)) u_aphase (
    .clk(clk), .rst_n(rst_n), .hready_in(hready_in), .htrans(htrans),
    .sel_mem(sel_mem), .sel_reg(sel_reg), .sel_dma(sel_dma),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
    .dp_valid(dp_valid), .dp_region(dp_region), .dp_write(dp_write),
    .dp_be(dp_be), .dp_addr(dp_addr)
  );

  // Data-phase classification
  always_comb begin
    mem_phase = dp_valid && ((dp_region == RG_MEM) ||
                             (dp_region == RG_DMA && !dp_write));
    err_phase = dp_valid && (dp_region == RG_DMA) && dp_write;
    mem_we    = dp_valid && (dp_region == RG_MEM) && dp_write && arb_gnt;
    reg_we    = dp_valid && (dp_region == RG_REG) && dp_write;
    err_d     = err_phase && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  ahbs_sram #(.WORDS(MEM_WORDS)) u_sram (
    .clk(clk), .wr_en(mem_we), .idx(dp_addr[MIW+1:2]), .be(dp_be),
    .wdata(hwdata), .rdata(mem_rdata)
  );

  ahbs_reg_field #(
    .AW(AW), .CFG_ID(CFG_ID), .MEM_WORDS(MEM_WORDS),
    .PCI_WORDS(PCI_WORDS), .AHB_WORDS(AHB_WORDS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(dp_addr), .be(dp_be),
    .wdata(hwdata), .pci_regs(pci_regs), .rdata(reg_rdata)
  );

  always_comb begin
    arb_req   = mem_phase;
    hresp     = err_phase;
    hreadyout = 1'b1;
    if (err_phase)      hreadyout = err_q;
    else if (mem_phase) hreadyout = arb_gnt;
    hrdata = '0;
    if (dp_valid && dp_region == RG_REG) hrdata = reg_rdata;
    else if (mem_phase)                  hrdata = mem_rdata;
  end

endmodule

// File: rtl/ahbs_dual_region_slave_chk.sv
module ahbs_dual_region_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_mem,
  input logic       sel_reg,
  input logic       sel_dma,
  input logic [1:0] htrans,
  input logic       hready_in,
  input logic       hreadyout,
  input logic       hresp,
  input logic       arb_req,
  input logic       arb_gnt
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hready_in) |-> $onehot0({sel_mem, sel_reg, sel_dma})); // R11

  AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && !arb_gnt) |-> !hreadyout); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && !arb_gnt) |=> arb_req); // R6

  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout)); // R9

  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && hreadyout) |-> $past(hresp && !hreadyout)); // R9

  AST_REQ_FROM_APHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_req) |-> $past(hready_in && htrans[1] && (sel_mem || sel_dma))); // R10

endmodule

bind ahbs_dual_region_slave ahbs_dual_region_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_mem(sel_mem), .sel_reg(sel_reg),
  .sel_dma(sel_dma), .htrans(htrans), .hready_in(hready_in),
  .hreadyout(hreadyout), .hresp(hresp), .arb_req(arb_req), .arb_gnt(arb_gnt)
);

// File: tb/ahbs_dual_region_slave_tb.sv
module ahbs_dual_region_slave_tb;

  localparam int          AW        = 12;
  localparam int          MEM_WORDS = 64;
  localparam int          PCI_WORDS = 4;
  localparam int          AHB_WORDS = 13;
  localparam logic [31:0] CFG_ID    = 32'hB51D_0001;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    sel_mem, sel_reg, sel_dma;
  logic [AW-1:0]           haddr;
  logic [1:0]              htrans;
  logic                    hwrite;
  logic [2:0]              hsize;
  logic [31:0]             hwdata;
  logic                    hready_in;
  logic [31:0]             hrdata;
  logic                    hreadyout, hresp, arb_req;
  logic                    arb_gnt;
  logic [32*PCI_WORDS-1:0] pci_regs;

  int checks = 0;
  int fails  = 0;
  int gnt_delay = 0;
  int gnt_cnt = 0;

  logic [31:0] mem_m [MEM_WORDS];
  logic        mem_known [MEM_WORDS];
  logic [31:0] ahb_m [AHB_WORDS];

  always #10 clk = ~clk;
  assign hready_in = hreadyout;

  ahbs_dual_region_slave #(
    .AW(AW), .MEM_WORDS(MEM_WORDS), .PCI_WORDS(PCI_WORDS),
    .AHB_WORDS(AHB_WORDS), .CFG_ID(CFG_ID)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_mem(sel_mem), .sel_reg(sel_reg),
    .sel_dma(sel_dma), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp), .arb_req(arb_req),
    .arb_gnt(arb_gnt), .pci_regs(pci_regs)
  );

  // Arbiter model: grants gnt_delay cycles after the request appears
  always @(posedge clk) begin
    #2;
    if (!arb_req) begin
      arb_gnt = 1'b0;
      gnt_cnt = 0;
    end else if (gnt_cnt >= gnt_delay) begin
      arb_gnt = 1'b1;
    end else begin
      arb_gnt = 1'b0;
      gnt_cnt++;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] be_of(input logic [2:0] sz, input logic [1:0] lo);
    if (sz == 3'd0)      be_of = 4'b0001 << lo;
    else if (sz == 3'd1) be_of = lo[1] ? 4'b1100 : 4'b0011;
    else                 be_of = 4'b1111;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    for (int b = 0; b < 4; b++) merge[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
  endfunction

  function automatic logic [31:0] exp_reg(input logic [AW-1:0] a);
    int w;
    exp_reg = '0;
    w = int'(a[7:2]);
    if (a[AW-1:8] != '0)                 exp_reg = '0;
    else if (w == 0)                     exp_reg = CFG_ID;
    else if (w == 1)                     exp_reg = MEM_WORDS;
    else if (w >= 16 && w < 16+PCI_WORDS) exp_reg = pci_regs[32*(w-16) +: 32];
    else if (w >= 32 && w < 32+AHB_WORDS) exp_reg = ahb_m[w-32];
  endfunction

  // rg: 1 = memory select, 2 = register select, 3 = DMA select
  task automatic xfer(input int rg, input logic [AW-1:0] a, input logic w,
                      input logic [2:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic rsp, output int waits,
                      output logic err_first);
    @(negedge clk);
    sel_mem = (rg == 1); sel_reg = (rg == 2); sel_dma = (rg == 3);
    haddr = a; htrans = 2'b10; hwrite = w; hsize = sz;
    @(negedge clk);
    sel_mem = 0; sel_reg = 0; sel_dma = 0; htrans = 2'b00; hwdata = wd;
    waits = 0; err_first = 0;
    while (!hreadyout && waits < 20) begin
      if (hresp) err_first = 1;
      waits++;
      @(negedge clk);
    end
    rd = hrdata; rsp = hresp;
  endtask

  logic [31:0] rd;
  logic        rsp, ef;
  int          wt;

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; sel_mem = 0; sel_reg = 0; sel_dma = 0; haddr = '0; htrans = 0;
    hwrite = 0; hsize = 3'd2; hwdata = '0; arb_gnt = 0;
    pci_regs = {32'hC0DE_0003, 32'hC0DE_0002, 32'h1234_5601, 32'hA5A5_0F0F};
    for (int i = 0; i < AHB_WORDS; i++) ahb_m[i] = '0;
    for (int i = 0; i < MEM_WORDS; i++) mem_known[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hreadyout === 1'b1, "R1 hreadyout in reset", 32'(hreadyout), 1);
    check(hresp === 1'b0, "R1 hresp in reset", 32'(hresp), 0);
    check(arb_req === 1'b0, "R1 arb_req in reset", 32'(arb_req), 0);
    rst_n = 1;
    xfer(2, 12'h080, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'h0, "R1 AHB register reset value", rd, 0);

    // R5 constant and PCI-side reads
    for (int i = 0; i < 4; i++) begin
      xfer(2, AW'(4*i), 0, 3'd2, 0, rd, rsp, wt, ef);
      check(rd === exp_reg(AW'(4*i)), "R5 config group", rd, exp_reg(AW'(4*i)));
      xfer(2, AW'(12'h40 + 4*i), 0, 3'd2, 0, rd, rsp, wt, ef);
      check(rd === pci_regs[32*i +: 32], "R5 PCI-side group", rd, pci_regs[32*i +: 32]);
    end

    // R2 aliasing: same offset, different storage
    gnt_delay = 0;
    xfer(1, 12'h080, 1, 3'd2, 32'hDEAD_BEEF, rd, rsp, wt, ef);
    mem_m[32] = 32'hDEAD_BEEF; mem_known[32] = 1;
    xfer(2, 12'h080, 1, 3'd2, 32'h0BAD_F00D, rd, rsp, wt, ef);
    ahb_m[0] = 32'h0BAD_F00D;
    xfer(1, 12'h080, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'hDEAD_BEEF, "R2 SRAM word after register write", rd, 32'hDEAD_BEEF);
    xfer(2, 12'h080, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'h0BAD_F00D, "R2 register after SRAM write", rd, 32'h0BAD_F00D);

    // R3 last writable word
    xfer(2, 12'h0B0, 1, 3'd2, 32'h1357_9BDF, rd, rsp, wt, ef);
    ahb_m[12] = 32'h1357_9BDF;
    xfer(2, 12'h0B0, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'h1357_9BDF, "R3 offset 0xB0 readback", rd, 32'h1357_9BDF);

    // R4 protected writes ignored, OKAY, zero wait
    xfer(2, 12'h000, 1, 3'd2, 32'hFFFF_FFFF, rd, rsp, wt, ef);
    check(rsp === 1'b0 && wt == 0, "R4 config write response", {rsp, 31'(wt)}, 0);
    xfer(2, 12'h000, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === CFG_ID, "R4 config unchanged", rd, CFG_ID);
    xfer(2, 12'h044, 1, 3'd2, 32'h0, rd, rsp, wt, ef);
    xfer(2, 12'h044, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === pci_regs[63:32], "R4 PCI-side unchanged", rd, pci_regs[63:32]);
    xfer(2, 12'h0B4, 1, 3'd2, 32'h7777_7777, rd, rsp, wt, ef);
    xfer(2, 12'h0B4, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'h0, "R4 unmapped stays zero", rd, 0);
    xfer(2, 12'h180, 1, 3'd2, 32'h5555_5555, rd, rsp, wt, ef);
    xfer(2, 12'h080, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === ahb_m[0], "R4 high offset does not alias 0x80", rd, ahb_m[0]);

    // R6 grant wait count
    gnt_delay = 3;
    xfer(1, 12'h010, 1, 3'd2, 32'hCAFE_0010, rd, rsp, wt, ef);
    mem_m[4] = 32'hCAFE_0010; mem_known[4] = 1;
    check(wt == 3, "R6 write waits for grant", wt, 3);
    xfer(1, 12'h010, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(wt == 3 && rd === 32'hCAFE_0010, "R6 read after grant", rd, 32'hCAFE_0010);

    // R9 DMA write error, SRAM unchanged
    gnt_delay = 1;
    xfer(3, 12'h010, 1, 3'd2, 32'h0, rd, rsp, wt, ef);
    check(ef === 1'b1 && wt == 1 && rsp === 1'b1, "R9 two-cycle ERROR",
          {ef, rsp, 30'(wt)}, {2'b11, 30'd1});
    xfer(3, 12'h010, 0, 3'd2, 0, rd, rsp, wt, ef);
    check(rd === 32'hCAFE_0010 && rsp === 1'b0, "R8 R9 DMA read after DMA write", rd,
          32'hCAFE_0010);

    // R10 pipelined register writes then reads
    @(negedge clk);
    sel_reg = 1; haddr = 12'h088; htrans = 2'b10; hwrite = 1; hsize = 3'd2;
    @(negedge clk);
    haddr = 12'h08C; hwdata = 32'hAAAA_0001;
    check(hreadyout === 1'b1, "R10 first write no wait", 32'(hreadyout), 1);
    @(negedge clk);
    sel_reg = 0; htrans = 2'b00; hwdata = 32'hBBBB_0002;
    check(hreadyout === 1'b1, "R10 second write no wait", 32'(hreadyout), 1);
    ahb_m[2] = 32'hAAAA_0001; ahb_m[3] = 32'hBBBB_0002;
    @(negedge clk);
    sel_reg = 1; haddr = 12'h088; htrans = 2'b10; hwrite = 0;
    @(negedge clk);
    haddr = 12'h08C; hwdata = 32'hFFFF_FFFF;
    check(hrdata === 32'hAAAA_0001, "R10 pipelined read 0x88", hrdata, 32'hAAAA_0001);
    @(negedge clk);
    sel_reg = 0; htrans = 2'b00;
    check(hrdata === 32'hBBBB_0002, "R10 pipelined read 0x8C", hrdata, 32'hBBBB_0002);

    // Random mix: R3 R6 R7 R8 against models
    for (int n = 0; n < 400; n++) begin
      int          rg, w, idx;
      logic [2:0]  sz;
      logic [AW-1:0] a;
      logic [31:0] wd, ex;
      logic        wr;
      rg = 1 + int'($urandom % 3);
      sz = 3'($urandom % 3);
      wr = 1'($urandom % 2);
      wd = $urandom;
      gnt_delay = int'($urandom % 4);
      if (rg == 2) a = AW'(12'h080 + 4*($urandom % AHB_WORDS) + ($urandom % 4));
      else         a = AW'($urandom % 256);
      if (sz == 3'd1) a[0] = 1'b0;
      if (sz == 3'd2) a[1:0] = 2'b00;
      if (rg == 3) wr = 0;
      idx = int'(a[7:2]);
      if (rg != 2 && !mem_known[idx]) begin
        xfer(1, {a[AW-1:2], 2'b00}, 1, 3'd2, 32'h0, rd, rsp, wt, ef);
        mem_m[idx] = 0; mem_known[idx] = 1;
      end
      xfer(rg, a, wr, sz, wd, rd, rsp, wt, ef);
      if (rg != 2) check(wt == gnt_delay, "R6 random wait count", wt, gnt_delay);
      if (wr) begin
        if (rg == 1) mem_m[idx] = merge(mem_m[idx], wd, be_of(sz, a[1:0]));
        else begin
          w = idx - 32;
          ahb_m[w] = merge(ahb_m[w], wd, be_of(sz, a[1:0]));
        end
      end else begin
        ex = (rg == 2) ? exp_reg(a) : mem_m[idx];
        check(rd === ex, rg == 3 ? "R8 DMA read" : "R7 R3 random read", rd, ex);
      end
    end
    // final sweep of AHB-side registers (R3 R7)
    for (int i = 0; i < AHB_WORDS; i++) begin
      xfer(2, AW'(12'h080 + 4*i), 0, 3'd2, 0, rd, rsp, wt, ef);
      check(rd === ahb_m[i], "R7 lane-merged register", rd, ahb_m[i]);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule